// File: doc/BRIEF.md
# Standby Rail Power Sequencer

This controller decides which supply rails of a standby-powered board are switched on. It keeps track of the power-management state: startup, active, suspend-to-RAM (S3) or soft-off (S4/S5). The standby bias comparator starts the sequence, and the two active-low sleep pins select the state once startup is done. Soft-start ramps, undervoltage comparators and regulators lie outside the block. They reach it as single-bit flags that are already synchronous to `clk`.

Startup runs in a fixed order. When the bias supply is good, the two standby rails are enabled. Once both report that their ramp is complete, a programmable delay runs, nominally 3 ms. At its end the memory-voltage select is captured and the remaining rails may come up.

A configuration bit sets whether the 5 V dual rail stays on during sleep. That bit can change only while the block is not asleep. Illegal state requests are refused: a direct move between the two sleep states, and the sleep-pin combination that is not allowed. An undervoltage on a live rail shuts every rail off until shutdown or loss of bias.

Top module: `acpi_rail_seq`

## Requirements
- R1: While `bias_ok`=1, `shutdown_req`=0 and no fault is latched, startup enables only the standby rails, `rail_en[0]` (1.8 V standby) and `rail_en[1]` (3.3 V standby), with `state_code`=00. Rail index map: 0 = 1.8 V standby, 1 = 3.3 V standby, 2 = memory, 3 = clock chip, 4 = 5 V dual.
- R2: `rail_en[4:2]` stay 0 until `ramp_done[1:0]` are both 1 and DELAY_CYC further cycles have passed.
- R3: The synchronized sleep pins {`slp5_n`,`slp3_n`} decode as 11 = active, 10 = S3 and 00 = S4/S5. The resulting `state_code` is 01 for active, 10 for S3 and 11 for S4/S5; startup, off and fault read 00. Active enables all five rails. S3 enables rails 0, 1 and 2. S4/S5 enables rails 0 and 1. The pins pass through two flops, so the state follows them three cycles after they change.
- R4: The pin combination 01 leaves the current state unchanged.
- R5: A direct request from S3 to S4/S5, or from S4/S5 to S3, is refused, and the state stays where it is.
- R6: The 5 V dual rail (`rail_en[4]`) is on in the active state. In S3 and S4/S5 it equals the stored `dual_cfg` bit.
- R7: The stored `dual_cfg` bit follows the pin in every state except S3 and S4/S5. A change made while asleep has no effect.
- R8: The clock-chip rail (`rail_en[3]`) is on only in the active state.
- R9: When `bias_ok`=0 or `shutdown_req`=1 is sampled at a clock edge, all enables are 0 and `state_code`=00 after that edge.
- R10: When a rail is enabled, reports `ramp_done`, and raises `uv_flag`, `fault` is set and all enables drop after the next edge. The fault holds until `bias_ok`=0 or `shutdown_req`=1.
- R11: `mem_vsel` captures `mem_sel` at the end of the startup delay. Later changes on `mem_sel` do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bias_ok | input | 1 | Standby bias above power-on threshold |
| shutdown_req | input | 1 | Forces all rails off, clears fault |
| slp5_n | input | 1 | Active-low soft-off sleep pin (asynchronous) |
| slp3_n | input | 1 | Active-low suspend sleep pin (asynchronous) |
| dual_cfg | input | 1 | Keep 5 V dual rail on while asleep |
| mem_sel | input | 1 | Memory-voltage select, captured after delay |
| ramp_done | input | 5 | Soft-start complete flag per rail |
| uv_flag | input | 5 | Undervoltage flag per rail |
| rail_en | output | 5 | Enable per rail |
| state_code | output | 2 | 00 startup/off/fault, 01 active, 10 S3, 11 S4/S5 |
| fault | output | 1 | Latched undervoltage fault |
| mem_vsel | output | 1 | Captured memory-voltage select |

## Verification
The bench drives random sleep-pin and configuration sequences and targets three corner cases.

- A direct S3 to S4/S5 request. A design that takes it would drop the memory rail in mid-suspend.
- The forbidden 01 code. A design that decodes it would leave the current state.
- A `dual_cfg` toggle while asleep. A design that does not freeze the bit would switch the 5 V dual rail.

The bench also checks that the late rails stay off just before the startup delay ends. An off-by-one counter, or one that starts on the first ramp flag, fails there. After an undervoltage, a design that cleared the fault as soon as `uv_flag` fell would power up again without a shutdown.

// File: rtl/seq_pkg.sv
// Shared types for the rail sequencer: state encoding and rail indices.
package seq_pkg;
    localparam int NUM_RAILS = 5;
    localparam int RAIL_1V8  = 0;
    localparam int RAIL_3V3  = 1;
    localparam int RAIL_MEM  = 2;
    localparam int RAIL_CLK  = 3;
    localparam int RAIL_DUAL = 4;

    typedef enum logic [2:0] {
        PH_OFF, PH_RAMP, PH_WAIT, PH_ACT, PH_SUSP, PH_SOFF, PH_FAULT
    } phase_t;

    typedef enum logic [1:0] {
        REQ_SOFF = 2'b00, REQ_BAD = 2'b01, REQ_SUSP = 2'b10, REQ_ACT = 2'b11
    } req_t;
endpackage

// File: rtl/seq_sync2.sv
// Two-flop synchronizer for WIDTH asynchronous level inputs.
// Assumes inputs are quasi-static levels; resets to RST_VAL.
module seq_sync2 #(
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Shift the asynchronous level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/seq_delay.sv
// Post-ramp delay counter. Held at zero while clr is high; saturates and
// raises done once DELAY_CYC-1 is reached. Assumes DELAY_CYC >= 2.
module seq_delay #(
    parameter int DELAY_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    // Count up while enabled, stop at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (!done)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/seq_rail_map.sv
// Combinational map from sequencer phase to rail enables and state code.
// Assumes dual_keep is the stored sleep-time 5 V dual configuration.
module seq_rail_map
    import seq_pkg::*;
(
    input  phase_t               ph,
    input  logic                 dual_keep,
    output logic [NUM_RAILS-1:0] en,
    output logic [1:0]           code
);
    // Decode enables and code for each phase.
    always_comb begin
        en   = '0;
        code = 2'b00;
        unique case (ph)
            PH_RAMP, PH_WAIT: begin
                en[RAIL_1V8] = 1'b1;
                en[RAIL_3V3] = 1'b1;
            end
            PH_ACT: begin
                en   = '1;
                code = 2'b01;
            end
            PH_SUSP: begin
                en[RAIL_1V8]  = 1'b1;
                en[RAIL_3V3]  = 1'b1;
                en[RAIL_MEM]  = 1'b1;
                en[RAIL_DUAL] = dual_keep;
                code          = 2'b10;
            end
            PH_SOFF: begin
                en[RAIL_1V8]  = 1'b1;
                en[RAIL_3V3]  = 1'b1;
                en[RAIL_DUAL] = dual_keep;
                code          = 2'b11;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acpi_rail_seq.sv
// Top of the standby rail sequencer. Tracks startup, active and sleep
// phases, refuses illegal sleep transitions, freezes the 5 V dual config
// while asleep and latches an undervoltage fault.
// Assumes bias_ok, shutdown_req, ramp_done and uv_flag are synchronous to clk;
// the sleep pins are asynchronous and are synchronized here.
module acpi_rail_seq
    import seq_pkg::*;
#(
    parameter int DELAY_CYC = 300000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bias_ok,
    input  logic                 shutdown_req,
    input  logic                 slp5_n,
    input  logic                 slp3_n,
    input  logic                 dual_cfg,
    input  logic                 mem_sel,
    input  logic [NUM_RAILS-1:0] ramp_done,
    input  logic [NUM_RAILS-1:0] uv_flag,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic [1:0]           state_code,
    output logic                 fault,
    output logic                 mem_vsel
);
    phase_t     ph, ph_nxt;
    logic [1:0] pins_s;
    req_t       req;
    logic       dly_done;
    logic       dual_q;
    logic       uv_hit;
    logic       asleep;

    seq_sync2 #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({slp5_n, slp3_n}),
        .q    (pins_s)
    );

    assign req = req_t'(pins_s);

    seq_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ph != PH_WAIT),
        .done (dly_done)
    );

    seq_rail_map u_map (
        .ph       (ph),
        .dual_keep(dual_q),
        .en       (rail_en),
        .code     (state_code)
    );

    assign uv_hit = |(rail_en & ramp_done & uv_flag);
    assign asleep = (ph == PH_SUSP) || (ph == PH_SOFF);
    assign fault  = (ph == PH_FAULT);

    // Next phase: kill conditions first, then fault, then legal moves only.
    always_comb begin
        ph_nxt = ph;
        if (!bias_ok || shutdown_req) begin
            ph_nxt = PH_OFF;
        end else if (ph != PH_OFF && ph != PH_FAULT && uv_hit) begin
            ph_nxt = PH_FAULT;
        end else begin
            unique case (ph)
                PH_OFF:  ph_nxt = PH_RAMP;
                PH_RAMP: if (ramp_done[RAIL_1V8] && ramp_done[RAIL_3V3])
                             ph_nxt = PH_WAIT;
                PH_WAIT: if (dly_done) begin
                             unique case (req)
                                 REQ_ACT:  ph_nxt = PH_ACT;
                                 REQ_SUSP: ph_nxt = PH_SUSP;
                                 REQ_SOFF: ph_nxt = PH_SOFF;
                                 default:  ph_nxt = PH_WAIT;
                             endcase
                         end
                PH_ACT:  if (req == REQ_SUSP)      ph_nxt = PH_SUSP;
                         else if (req == REQ_SOFF) ph_nxt = PH_SOFF;
                PH_SUSP, PH_SOFF:
                         if (req == REQ_ACT)       ph_nxt = PH_ACT;
                default: ph_nxt = ph;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_OFF;
        else        ph <= ph_nxt;
    end

    // Dual-rail config follows its pin except while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n)       dual_q <= 1'b0;
        else if (!asleep) dual_q <= dual_cfg;
    end

    // Memory-voltage select is captured once the startup delay ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mem_vsel <= 1'b0;
        else if (ph == PH_WAIT && dly_done)  mem_vsel <= mem_sel;
    end
endmodule

// File: rtl/acpi_rail_seq_chk.sv
// Property checker for acpi_rail_seq, attached by bind below.
module acpi_rail_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bias_ok,
    input logic       shutdown_req,
    input logic [4:0] rail_en,
    input logic [1:0] state_code,
    input logic       fault
);
    // R8
    clk_rail_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[3] |-> state_code == 2'b01);

    // R5
    no_susp_to_soff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b10 |=> state_code != 2'b11);

    // R5
    no_soff_to_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b11 |=> state_code != 2'b10);

    // R9
    kill_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_ok || shutdown_req) |=> (rail_en == 5'b0 && state_code == 2'b00));

    // R10
    fault_rails_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> rail_en == 5'b0);

    // R6
    dual_on_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b01 |-> rail_en[4]);

    // R7
    dual_frozen_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b10 && $past(state_code) == 2'b10) |-> $stable(rail_en[4]));
endmodule

bind acpi_rail_seq acpi_rail_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bias_ok     (bias_ok),
    .shutdown_req(shutdown_req),
    .rail_en     (rail_en),
    .state_code  (state_code),
    .fault       (fault)
);

// File: tb/sim_acpi_rail_seq.sv
`timescale 1ns/1ps
module sim_acpi_rail_seq;
    localparam int D = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bias_ok = 1'b0, shutdown_req = 1'b0;
    logic       slp5_n = 1'b1, slp3_n = 1'b1;
    logic       dual_cfg = 1'b0, mem_sel = 1'b0;
    logic [4:0] ramp_done = '0, uv_flag = '0;
    logic [4:0] rail_en;
    logic [1:0] state_code;
    logic       fault, mem_vsel;

    int checks = 0, errors = 0;
    int mst;      // model: 1 active, 2 S3, 3 S4/S5
    logic mdual;  // model stored dual configuration

    acpi_rail_seq #(.DELAY_CYC(D)) u0 (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [4:0] exp_en(input int st, input logic dl);
        case (st)
            1: return 5'b11111;
            2: return {dl, 4'b0111};
            3: return {dl, 4'b0011};
            default: return 5'b0;
        endcase
    endfunction

    // Next model state for pin code {s5,s3}, per R3, R4, R5.
    function automatic int next_st(input int st, input logic [1:0] p);
        if (st == 1) return (p == 2'b10) ? 2 : (p == 2'b00) ? 3 : 1;
        return (p == 2'b11) ? 1 : st;
    endfunction

    task automatic apply(input logic [1:0] p, input logic dl);
        slp5_n = p[1]; slp3_n = p[0]; dual_cfg = dl;
        if (mst == 1 || next_st(mst, p) == 1) mdual = dl;
        mst = next_st(mst, p);
        cyc(6);
    endtask

    task automatic check_state(input string req);
        check(req, {6'b0, state_code}, 8'(mst));
        check(req, {3'b0, rail_en}, {3'b0, exp_en(mst, mdual)});
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R9 reset rails", {3'b0, rail_en}, 8'h00);
        check("R3 reset code", {6'b0, state_code}, 8'h00);
        check("R10 reset fault", {7'b0, fault}, 8'h0);

        // Startup with mem_sel=1
        mem_sel = 1'b1; dual_cfg = 1'b0; mdual = 1'b0;
        bias_ok = 1'b1;
        cyc(3);
        check("R1 standby rails only", {3'b0, rail_en}, 8'h03);
        ramp_done = 5'b00001;
        cyc(4);
        check("R2 one ramp not enough", {3'b0, rail_en}, 8'h03);
        ramp_done = 5'b11111;
        cyc(D - 2);
        check("R2 late rails off before delay", {3'b0, rail_en}, 8'h03);
        check("R1 code during startup", {6'b0, state_code}, 8'h00);
        cyc(5);
        mst = 1;
        check_state("R3 active after delay");
        check("R11 mem select captured", {7'b0, mem_vsel}, 8'h1);
        mem_sel = 1'b0;
        cyc(4);
        check("R11 mem select held", {7'b0, mem_vsel}, 8'h1);

        // Directed: S3 then direct S4/S5 request refused
        apply(2'b10, 1'b1);
        check_state("R3 S3 entry");
        check("R6 dual kept in S3", {7'b0, rail_en[4]}, 8'h1);
        apply(2'b00, 1'b1);
        check_state("R5 S3 to S4/S5 refused");
        check("R5 still S3", {6'b0, state_code}, 8'h2);
        apply(2'b00, 1'b0);
        check("R7 dual change in S3 ignored", {7'b0, rail_en[4]}, 8'h1);
        apply(2'b01, 1'b0);
        check_state("R4 forbidden holds S3");
        apply(2'b11, 1'b0);
        check("R8 clock rail in active", {7'b0, rail_en[3]}, 8'h1);
        apply(2'b00, 1'b0);
        check("R7 dual change in active used", {7'b0, rail_en[4]}, 8'h0);
        check("R8 clock rail off in S4/S5", {7'b0, rail_en[3]}, 8'h0);
        apply(2'b10, 1'b1);
        check_state("R5 S4/S5 to S3 refused");
        apply(2'b11, 1'b1);
        apply(2'b01, 1'b1);
        check_state("R4 forbidden holds active");

        // Random sequences
        for (int i = 0; i < 150; i++) begin
            logic [1:0] p;
            logic dl;
            p  = 2'($urandom);
            dl = 1'($urandom);
            apply(p, dl);
            check_state("R3 R6 R7 random step");
        end

        // Fault on clock rail
        apply(2'b11, 1'b0);
        uv_flag = 5'b01000;
        cyc(2);
        check("R10 fault set", {7'b0, fault}, 8'h1);
        check("R10 rails off", {3'b0, rail_en}, 8'h00);
        uv_flag = '0;
        cyc(5);
        check("R10 fault held", {7'b0, fault}, 8'h1);
        shutdown_req = 1'b1;
        cyc(2);
        check("R9 shutdown off", {3'b0, rail_en}, 8'h00);
        check("R10 fault cleared", {7'b0, fault}, 8'h0);
        shutdown_req = 1'b0;
        cyc(D + 8);
        mst = 1;
        check_state("R2 repower after shutdown");

        bias_ok = 1'b0;
        cyc(1);
        check("R9 bias loss rails off", {3'b0, rail_en}, 8'h00);
        check("R9 bias loss code", {6'b0, state_code}, 8'h00);
        finish_up();
    end
endmodule